// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block is a computer-operating-properly watchdog. It counts bus clocks through a free-running prescaler and a second counter whose length comes from a 3-bit rate select. If software lets the count reach the selected limit, the block raises a one-cycle reset request. Software keeps the system alive through a single service register. It first writes the arming key 0x55 and later writes the completing key 0xAA, which restarts the timeout. Writes to other registers may fall between the two keys.

A write of any other value to the service register is treated as runaway code and raises the reset request at once. The service register reads back as zero. The oscillator, clock generation and the system reset controller lie outside this block. The block only delivers the request pulse.

Top module: `keyseq_wdog`

## Requirements
- R1: `rd_data` is 0x00 at all times, whatever has been written to the service register.
- R2: A service-register write of 0xAA while a 0x55 is pending restarts the timeout from that write and clears the pending state.
- R3: Writes with `svc_sel` low, whatever their data, neither break a pending sequence nor complete it nor raise a reset.
- R4: A service-register write of 0xAA with no 0x55 pending does not restart the timeout and raises no reset.
- R5: A second 0x55 while already armed keeps the sequence armed, so a following 0xAA still completes it.
- R6: With the watchdog enabled, a service-register write of any value other than 0x55 or 0xAA makes `wdog_rst` high for the cycle after the write edge.
- R7: The nominal timeout is 2^(P+s) bus clocks, where P is `PRE_BITS` (13 by default) and s is 0, 2, 4, 6, 8, 9, 10 for `rate_sel` values 1 to 7. `rate_sel` 0 disables the watchdog.
- R8: Counting from the last restart, the timeout pulse arrives no earlier than the nominal count and at most 2^P clocks later. The 2^P-clock prescaler runs freely and is not cleared by servicing.
- R9: While `rate_sel` is 0, the counter is held clear and no reset is raised, neither by timeout nor by illegal writes.
- R10: `wdog_rst` lasts one cycle. After it fires, the counter restarts from zero and the pending key is dropped, so a later lone 0xAA does not restart the timeout.
- R11: The synchronous reset `rst` clears all state and holds `wdog_rst` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| rate_sel | input | 3 | Timeout rate select, 0 disables |
| wr_en | input | 1 | Register write strobe |
| svc_sel | input | 1 | Write targets the service register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Service register read value, always zero |
| wdog_rst | output | 1 | One-cycle watchdog reset request |

## Verification
The bench measures every timeout pulse against a window running from the last restart. A design that cleared the prescaler on service, or that decoded a rate wrongly, lands outside the window. It sends a lone 0xAA, and a 0xAA just after a timeout, at moments where a wrongful restart would push the next pulse past its window. It then confirms that bad keys pulse on the very next cycle when enabled and stay silent when disabled. Foreign-register writes placed between the keys catch a design that decodes keys without the register select.

// File: rtl/keyseq_wdog.sv
module keyseq_wdog #(
  parameter int          PRE_BITS = 13,
  parameter int          DW       = 8,
  parameter logic [DW-1:0] KEY_ARM  = 8'h55,
  parameter logic [DW-1:0] KEY_DONE = 8'hAA
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    rate_sel,
  input  logic          wr_en,
  input  logic          svc_sel,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          wdog_rst
);
  // Longest chain is 2^10 prescaler periods; one extra bit for the limit itself.
  localparam int MAX_SH = 10;
  localparam int CW     = MAX_SH + 1;

  logic [PRE_BITS-1:0] pre_q;
  logic [CW-1:0]       cnt_q;
  logic                armed_q;
  logic                pulse_q;
  logic [3:0]          sh;
  logic [CW-1:0]       lim;

  always_comb begin
    case (rate_sel)
      3'd1:    sh = 4'd0;
      3'd2:    sh = 4'd2;
      3'd3:    sh = 4'd4;
      3'd4:    sh = 4'd6;
      3'd5:    sh = 4'd8;
      3'd6:    sh = 4'd9;
      default: sh = 4'd10;
    endcase
  end

  assign lim = CW'(1) << sh;

  wire en      = (rate_sel != 3'd0);
  wire tick    = &pre_q;
  wire svc_wr  = wr_en & svc_sel;
  wire key_arm = svc_wr && (wr_data == KEY_ARM);
  wire key_end = svc_wr && (wr_data == KEY_DONE);
  wire bad_wr  = svc_wr && !key_arm && !key_end;
  wire done    = key_end && armed_q;
  wire tmo     = en && tick && (cnt_q >= lim);
  wire fire    = tmo || (en && bad_wr);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q   <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pre_q   <= pre_q + 1'b1;
      pulse_q <= fire;
      if (fire || done || !en) cnt_q <= '0;
      else if (tick)           cnt_q <= cnt_q + 1'b1;
      if (fire || done)        armed_q <= 1'b0;
      else if (key_arm)        armed_q <= 1'b1;
    end
  end

  assign wdog_rst = pulse_q;
  assign rd_data  = '0;

  p_bad_key_r6: assert property (@(posedge clk) disable iff (rst)
    (svc_wr && en && (wr_data != KEY_ARM) && (wr_data != KEY_DONE)) |=> wdog_rst);

  p_complete_r2: assert property (@(posedge clk) disable iff (rst)
    (key_end && armed_q) |=> (cnt_q == '0 && !armed_q));

  p_rearm_r5: assert property (@(posedge clk) disable iff (rst)
    (armed_q && key_arm && !tmo) |=> armed_q);

  p_stray_key_r4: assert property (@(posedge clk) disable iff (rst)
    (key_end && !armed_q && !tmo) |=> !wdog_rst);

  p_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (rate_sel == 3'd0) |=> !wdog_rst);

  p_clear_r10: assert property (@(posedge clk) disable iff (rst)
    wdog_rst |-> (cnt_q == '0 && !armed_q));

  p_foreign_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !svc_sel && armed_q && !tmo) |=> armed_q);
endmodule

// File: tb/tb_keyseq_wdog.sv
module tb_keyseq_wdog;
  localparam int P = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] rate_sel = 3'd0;
  logic       wr_en = 1'b0;
  logic       svc_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       wdog_rst;

  keyseq_wdog #(.PRE_BITS(P)) dut (
    .clk(clk), .rst(rst), .rate_sel(rate_sel), .wr_en(wr_en),
    .svc_sel(svc_sel), .wr_data(wr_data), .rd_data(rd_data), .wdog_rst(wdog_rst)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int lo; int hi; string req; } exp_t;
  exp_t q[$];
  exp_t e;
  int n_chk = 0, n_fail = 0, n_pulse = 0, last_pulse = 0;
  bit ended = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (wdog_rst) begin
        n_pulse++;
        last_pulse = cyc;
        if (q.size() == 0) chk(1'b0, "R4 R9 unexpected pulse", cyc, -1);
        else begin
          e = q.pop_front();
          chk(cyc >= e.lo && cyc <= e.hi, e.req, cyc, e.lo);
        end
      end else if (q.size() > 0 && cyc > q[0].hi) begin
        e = q.pop_front();
        chk(1'b0, {e.req, " missed pulse"}, cyc, e.hi);
      end
    end
  end

  function automatic int nom(input int r);
    int s;
    case (r)
      1: s = 0; 2: s = 2; 3: s = 4; 4: s = 6; 5: s = 8; 6: s = 9; default: s = 10;
    endcase
    return 1 << (P + s);
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input bit sel, input logic [7:0] d, input string imm, output int n0);
    @(negedge clk);
    wr_en = 1'b1; svc_sel = sel; wr_data = d;
    n0 = cyc + 1;
    if (imm != "") q.push_back('{n0, n0, imm});
    @(negedge clk);
    wr_en = 1'b0; svc_sel = 1'b0; wr_data = 8'h00;
  endtask

  task automatic enable(input int r);
    @(negedge clk);
    rate_sel = 3'(r);
    q.push_back('{cyc + nom(r), cyc + nom(r) + (1 << P), "R7 R8 timeout"});
  endtask

  task automatic stop();
    @(negedge clk);
    rate_sel = 3'd0;
    q.delete();
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic service(input int r);
    int n0;
    q.delete();
    wr(1'b1, 8'hAA, "", n0);
    q.push_back('{n0 + nom(r), n0 + nom(r) + (1 << P), "R2 restart"});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int n0, p0;
    repeat (3) @(negedge clk);
    chk(wdog_rst == 1'b0, "R11 reset pulse", wdog_rst, 0);
    chk(rd_data == 8'h00, "R1 read at reset", rd_data, 0);
    rst = 1'b0;

    // R7 R8: every rate times out within its window
    for (int r = 1; r < 8; r++) begin
      enable(r); drain(); stop(); idle(3);
    end

    // R2 R3: keyed service with foreign writes between the keys
    enable(3);
    for (int i = 0; i < 4; i++) begin
      idle(40);
      wr(1'b1, 8'h55, "", n0);
      wr(1'b0, 8'h12, "", n0);
      wr(1'b0, 8'hAA, "", n0);
      wr(1'b0, 8'h00, "", n0);
      idle(10);
      service(3);
    end
    chk(rd_data == 8'h00, "R1 read after writes", rd_data, 0);
    drain(); stop(); idle(3);

    // R5: double arm then complete
    enable(3); idle(30);
    wr(1'b1, 8'h55, "", n0);
    wr(1'b1, 8'h55, "", n0);
    idle(10);
    service(3);
    drain(); stop(); idle(3);

    // R4: lone 0xAA leaves the original window in place
    enable(3); idle(60);
    wr(1'b1, 8'hAA, "", n0);
    drain(); stop(); idle(3);

    // R10: pending key dropped on timeout, pulse single cycle
    enable(2);
    wr(1'b1, 8'h55, "", n0);
    drain();
    idle(1);
    chk(wdog_rst == 1'b0, "R10 single-cycle pulse", wdog_rst, 0);
    p0 = last_pulse;
    q.push_back('{p0 + nom(2), p0 + nom(2) + (1 << P), "R10 restart after pulse"});
    idle(15);
    wr(1'b1, 8'hAA, "", n0);
    drain(); stop(); idle(3);

    // R6: bad keys pulse the next cycle
    enable(4);
    foreach (bad_vals[k]) begin
      idle(5);
      q.delete();
      wr(1'b1, bad_vals[k], "R6 bad key", n0);
      idle(2);
      chk(q.size() == 0, "R6 bad key seen", q.size(), 0);
    end
    stop(); idle(3);

    // R9: disabled, nothing fires
    p0 = n_pulse;
    wr(1'b1, 8'h33, "", n0);
    wr(1'b1, 8'h55, "", n0);
    wr(1'b1, 8'h00, "", n0);
    idle(3000);
    chk(n_pulse == p0, "R9 disabled quiet", n_pulse, p0);

    // R11: synchronous reset mid-count
    enable(1); idle(4);
    @(negedge clk); rst = 1'b1; q.delete();
    idle(2);
    chk(wdog_rst == 1'b0, "R11 reset holds output low", wdog_rst, 0);
    rate_sel = 3'd0;
    @(negedge clk); rst = 1'b0;
    idle(5);
    chk(rd_data == 8'h00, "R1 read at end", rd_data, 0);

    if (!ended) begin
      ended = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  logic [7:0] bad_vals [4] = '{8'h00, 8'h54, 8'hFF, 8'hAB};
endmodule